// File: doc/BRIEF.md
# Multi-mode multiply-accumulate slice

This block is a hard arithmetic slice for a programmable fabric. It sits apart from the general logic. It takes two operand words and forms signed two's-complement products in one of three partitions, chosen by a static `mode` input:

- **Quad narrow lanes.** Four independent lane products, combined in pairs.
- **Dual medium lanes.** Two half-width products, combined into one sum or difference.
- **Single wide product.** One full-width product.

In the two split partitions, a combining stage adds or subtracts the products under the `add_sub` control.

The slice registers its operands on the way in and registers the result on the way out. The operand A register can also load from the neighbouring slice's `shift_out` instead of from the A input port. A row of slices then forms a chain that passes the A operand along one slice per clock.

Top module: `mac_slice`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the A register, the B register, the registered `add_sub` and the result, so `result` and `shift_out` read zero after that edge.
- R2: An operand pair captured at edge N appears on `result` after edge N+1 and not before; a new pair may be presented every cycle.
- R3: With `mode` = 2'b00 each operand is cut into four signed lanes of LANE_W bits, lane k at bits [k*LANE_W +: LANE_W]. `result[OP_W-1:0]` is lane0 product combined with lane1 product, sign-extended to OP_W. `result[2*OP_W-1:OP_W]` is lane2 product combined with lane3 product, sign-extended to OP_W.
- R4: With `mode` = 2'b01 each operand is cut into two signed halves of 2*LANE_W bits, low half at the bottom. `result` is the low-half product combined with the high-half product, sign-extended to 2*OP_W bits.
- R5: With `mode` = 2'b10 or 2'b11, `result` is the full signed OP_W by OP_W product, and `add_sub` has no effect.
- R6: In the split modes, `add_sub` = 0 selects a sum and `add_sub` = 1 selects a difference (lower lane minus upper lane). `add_sub` is captured at the same edge as its operands.
- R7: While `shift_en` is high at an edge, the A register loads `shift_in` and ignores `a_in`; while `shift_en` is low it loads `a_in`.
- R8: `shift_out` always shows the current A register, so it equals the value loaded at the latest edge.
- R9: The B register loads `b_in` at every edge not in reset, whatever `shift_en` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | Partition select: 00 quad, 01 dual, 1x single |
| add_sub | input | 1 | 0 add, 1 subtract in the split modes |
| shift_en | input | 1 | A register takes `shift_in` instead of `a_in` |
| a_in | input | OP_W | Operand A |
| b_in | input | OP_W | Operand B |
| shift_in | input | OP_W | Chain input from the previous slice |
| shift_out | output | OP_W | Current A register, to the next slice |
| result | output | 2*OP_W | Registered combined product |

OP_W is 4*LANE_W; with the default LANE_W of 9 that is 36 bits.

## Verification
Every product is due two rising edges after its operands are driven: one edge to capture them and one to register the result. The bench therefore streams a new vector every cycle and compares each falling-edge sample against the expected value it computed two iterations earlier. The `shift_out` value is due one edge after the load, so it is sampled at the very next falling edge. Between mode sweeps the pipeline is drained with two idle cycles, so no result is ever judged under a mode other than the one it was computed in.

// File: rtl/mac_slice.sv
module mac_slice #(
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            mode,
  input  logic                  add_sub,
  input  logic                  shift_en,
  input  logic [4*LANE_W-1:0]   a_in,
  input  logic [4*LANE_W-1:0]   b_in,
  input  logic [4*LANE_W-1:0]   shift_in,
  output logic [4*LANE_W-1:0]   shift_out,
  output logic [8*LANE_W-1:0]   result
);
  localparam int OP_W   = 4 * LANE_W;
  localparam int HALF_W = 2 * LANE_W;
  localparam int RES_W  = 2 * OP_W;

  logic [OP_W-1:0]  a_q, b_q;
  logic             sub_q;
  logic [RES_W-1:0] res_d, res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q   <= '0;
      b_q   <= '0;
      sub_q <= 1'b0;
      res_q <= '0;
    end else begin
      a_q   <= shift_en ? shift_in : a_in;
      b_q   <= b_in;
      sub_q <= add_sub;
      res_q <= res_d;
    end
  end

  assign shift_out = a_q;
  assign result    = res_q;

  // quad narrow lanes
  logic [HALF_W-1:0] p9 [4];
  for (genvar k = 0; k < 4; k++) begin : g_q
    logic [LANE_W-1:0] la, lb;
    assign la = a_q[k*LANE_W +: LANE_W];
    assign lb = b_q[k*LANE_W +: LANE_W];
    assign p9[k] = {{LANE_W{la[LANE_W-1]}}, la} * {{LANE_W{lb[LANE_W-1]}}, lb};
  end

  logic [HALF_W:0] s9_lo, s9_hi;
  assign s9_lo = sub_q ? {p9[0][HALF_W-1], p9[0]} - {p9[1][HALF_W-1], p9[1]}
                       : {p9[0][HALF_W-1], p9[0]} + {p9[1][HALF_W-1], p9[1]};
  assign s9_hi = sub_q ? {p9[2][HALF_W-1], p9[2]} - {p9[3][HALF_W-1], p9[3]}
                       : {p9[2][HALF_W-1], p9[2]} + {p9[3][HALF_W-1], p9[3]};

  // dual medium lanes
  logic [OP_W-1:0] p18 [2];
  for (genvar k = 0; k < 2; k++) begin : g_d
    logic [HALF_W-1:0] ha, hb;
    assign ha = a_q[k*HALF_W +: HALF_W];
    assign hb = b_q[k*HALF_W +: HALF_W];
    assign p18[k] = {{HALF_W{ha[HALF_W-1]}}, ha} * {{HALF_W{hb[HALF_W-1]}}, hb};
  end

  logic [OP_W:0] s18;
  assign s18 = sub_q ? {p18[0][OP_W-1], p18[0]} - {p18[1][OP_W-1], p18[1]}
                     : {p18[0][OP_W-1], p18[0]} + {p18[1][OP_W-1], p18[1]};

  // single wide product
  logic [RES_W-1:0] p36;
  assign p36 = {{OP_W{a_q[OP_W-1]}}, a_q} * {{OP_W{b_q[OP_W-1]}}, b_q};

  always_comb begin
    case (mode)
      2'b00:   res_d = {{(OP_W-HALF_W-1){s9_hi[HALF_W]}}, s9_hi,
                        {(OP_W-HALF_W-1){s9_lo[HALF_W]}}, s9_lo};
      2'b01:   res_d = {{(RES_W-OP_W-1){s18[OP_W]}}, s18};
      default: res_d = p36;
    endcase
  end

  a_r1_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (res_q == '0 && a_q == '0 && b_q == '0));

  a_r7_shift_load: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> shift_out == $past(shift_in));

  a_r8_port_load: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> shift_out == $past(a_in));

  a_r9_b_load: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> b_q == $past(b_in));

  a_r2_zero_operand: assert property (@(posedge clk) disable iff (rst)
    $past(a_q) == '0 |-> res_q == '0);

  a_r3_lane_sign_ext: assert property (@(posedge clk) disable iff (rst)
    $past(mode) == 2'b00 |->
      (res_q[OP_W-1:HALF_W] == {(OP_W-HALF_W){res_q[HALF_W]}} &&
       res_q[RES_W-1:OP_W+HALF_W] == {(OP_W-HALF_W){res_q[OP_W+HALF_W]}}));

  a_r4_half_sign_ext: assert property (@(posedge clk) disable iff (rst)
    $past(mode) == 2'b01 |-> res_q[RES_W-1:OP_W] == {OP_W{res_q[OP_W]}});
endmodule

// File: tb/tb_mac_slice.sv
module tb_mac_slice;
  localparam int LW = 3;
  localparam int OW = 4 * LW;
  localparam int HW = 2 * LW;
  localparam int RW = 2 * OW;
  localparam int NV = 1 << OW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'b00;
  logic add_sub = 1'b0, shift_en = 1'b0;
  logic [OW-1:0] a_in = '0, b_in = '0, shift_in = '0;
  logic [OW-1:0] shift_out;
  logic [RW-1:0] result;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mac_slice #(.LANE_W(LW)) dut (
    .clk(clk), .rst(rst), .mode(mode), .add_sub(add_sub), .shift_en(shift_en),
    .a_in(a_in), .b_in(b_in), .shift_in(shift_in),
    .shift_out(shift_out), .result(result));

  function automatic logic [RW-1:0] model(logic [1:0] m, logic [OW-1:0] a,
                                          logic [OW-1:0] b, logic s);
    longint p [4];
    longint lo, hi, r;
    logic [RW-1:0] o;
    if (m == 2'b00) begin
      for (int k = 0; k < 4; k++)
        p[k] = longint'($signed(a[k*LW +: LW])) * longint'($signed(b[k*LW +: LW]));
      lo = s ? p[0] - p[1] : p[0] + p[1];
      hi = s ? p[2] - p[3] : p[2] + p[3];
      o = {hi[OW-1:0], lo[OW-1:0]};
    end else if (m == 2'b01) begin
      for (int k = 0; k < 2; k++)
        p[k] = longint'($signed(a[k*HW +: HW])) * longint'($signed(b[k*HW +: HW]));
      r = s ? p[0] - p[1] : p[0] + p[1];
      o = r[RW-1:0];
    end else begin
      r = longint'($signed(a)) * longint'($signed(b));
      o = r[RW-1:0];
    end
    return o;
  endfunction

  task automatic check(string tag, logic [RW-1:0] got, logic [RW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic sweep(logic [1:0] m, string tag);
    logic [RW-1:0] e0, e1;
    e0 = '0;
    e1 = '0;
    mode = m;
    for (int i = 0; i < NV + 2; i++) begin
      @(negedge clk);
      if (i >= 2) check(tag, result, e1);
      e1 = e0;
      if (i < NV) begin
        a_in    = i[OW-1:0];
        b_in    = OW'((i * 1637 + 291) ^ (i >> 5));
        add_sub = i[0] ^ i[6];
      end else begin
        a_in    = '0;
        b_in    = '0;
        add_sub = 1'b0;
      end
      e0 = model(m, a_in, b_in, add_sub);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 result", result, '0);
    check("R1 shift_out", {{OW{1'b0}}, shift_out}, '0);
    rst = 1'b0;

    // R2 latency: one edge after capture still old, two edges new
    mode = 2'b10;
    a_in = 12'h7A5;
    b_in = 12'h0C3;
    @(negedge clk);
    a_in = '0;
    b_in = '0;
    check("R2 early", result, '0);
    @(negedge clk);
    check("R2 due", result, model(2'b10, 12'h7A5, 12'h0C3, 1'b0));
    @(negedge clk);

    sweep(2'b00, "R3/R6 quad");
    sweep(2'b01, "R4/R6 dual");
    sweep(2'b10, "R5 single");
    sweep(2'b11, "R5 single-alt");

    // R6 add_sub captured with operands, not at result edge
    mode = 2'b01;
    a_in = 12'h5D3;
    b_in = 12'hE47;
    add_sub = 1'b1;
    @(negedge clk);
    add_sub = 1'b0;
    a_in = '0;
    b_in = '0;
    @(negedge clk);
    check("R6 sampled", result, model(2'b01, 12'h5D3, 12'hE47, 1'b1));

    // R7/R8/R9 shift chain load
    mode = 2'b10;
    shift_en = 1'b1;
    shift_in = 12'h9B2;
    a_in = 12'h123;
    b_in = 12'h0F7;
    @(negedge clk);
    check("R8 shift_out", {{OW{1'b0}}, shift_out}, {{OW{1'b0}}, 12'h9B2});
    shift_in = 12'h3C1;
    b_in = 12'h805;
    @(negedge clk);
    check("R7 a_in ignored", result, model(2'b10, 12'h9B2, 12'h0F7, 1'b0));
    check("R8 shift_out next", {{OW{1'b0}}, shift_out}, {{OW{1'b0}}, 12'h3C1});
    shift_en = 1'b0;
    a_in = 12'h444;
    b_in = 12'h002;
    @(negedge clk);
    check("R9 b during shift", result, model(2'b10, 12'h3C1, 12'h805, 1'b0));
    check("R7 port load", {{OW{1'b0}}, shift_out}, {{OW{1'b0}}, 12'h444});
    @(negedge clk);
    check("R9 b after shift", result, model(2'b10, 12'h444, 12'h002, 1'b0));

    // R1 mid-stream reset
    a_in = 12'h7FF;
    b_in = 12'h7FF;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid result", result, '0);
    check("R1 mid shift_out", {{OW{1'b0}}, shift_out}, '0);
    rst = 1'b0;
    a_in = '0;
    b_in = '0;
    @(negedge clk);
    check("R1 after", result, '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule